// File: doc/BRIEF.md
# Serial Memory Status Register Unit

This block holds the status register of a serial nonvolatile memory slave on a single-wire, byte-oriented bus. A byte-level bus engine passes it decoded tokens. A token is either a data byte (the start header, the device address, a command or a write payload) or an acknowledge token from the master. The unit decodes each transaction. It sets or clears the write-enable flag, starts a status write, and sends status bytes back.

A status read sends one status byte. It sends the byte again each time the master returns a positive acknowledge, so the master can poll the busy and write-enable flags without issuing a new command. A status write stores the two protect bits as pending values and starts an internal busy period of `WR_CYCLES` clock cycles. When that period ends, the protect bits commit to the register that stands in for nonvolatile storage, and the write-enable flag clears.

Both streams use valid/ready handshakes. An input token transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while a status byte waits to leave. An output byte transfers on an edge where `out_valid` and `out_ready` are both high. While the sink holds `out_ready` low, the byte and its valid flag stay unchanged. Acknowledge tokens that arrive outside the acknowledge phase are consumed and dropped.

Top module: `stsreg_unit`

## Requirements
- R1: After reset, WEL, WIP and both protect bits are 0, `out_valid` is 0 and `in_ready` is 1.
- R2: The token sequence 0x55 (header), 0xA0 (address), 0x05 (read) produces one status byte. Its layout is bits 7..4 = 0, bit 3 = BP1, bit 2 = BP0, bit 1 = WEL, bit 0 = WIP.
- R3: An acknowledge token (`in_kind`=1) with `in_data[0]`=1 makes the unit send the status byte again. An acknowledge token with `in_data[0]`=0 ends the read, and so does a data byte arriving in place of an acknowledge. After the read ends, no byte is sent until a new read command.
- R4: Command 0x06 sets WEL and command 0x04 clears WEL.
- R5: Command 0x01 is accepted only while WEL is 1. Bits 3..2 of the next data byte become the pending BP1..BP0. When WEL is 0, the command and its data byte change nothing.
- R6: An accepted status write makes WIP read 1 in every status byte captured during the next `WR_CYCLES` cycles. When that period ends, WIP and WEL read 0 and the pending protect bits read as committed.
- R7: While a status write is in progress, status bytes show the pending protect bits. Each repeated byte shows WIP and WEL as they are at the acknowledge that requested it.
- R8: An address other than 0xA0, or an unknown command, makes the unit ignore data bytes until the next 0x55.
- R9: Commands 0x06, 0x04 and 0x01 have no effect while WIP is 1.
- R10: `in_ready` is 0 while `out_valid` is 1. While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input token valid |
| in_ready | output | 1 | Unit can take an input token |
| in_kind | input | 1 | 0 = data byte, 1 = acknowledge token |
| in_data | input | 8 | Data byte, or acknowledge value in bit 0 (1 = positive) |
| out_valid | output | 1 | Status byte valid |
| out_ready | input | 1 | Sink takes the status byte |
| out_data | output | 8 | Status byte |

## Verification
Status reads are tried in four situations: just after reset, after each write-enable command, after each write-disable command, and across a status write with polls that span the end of the busy period. A correct unit shows WIP falling, WEL clearing and the protect bits changing from pending to committed values at exactly those poll cycles. A unit that samples the flags only once per command, or shows the old protect bits, gives different bytes. Malformed frames are also sent: a wrong address, an unknown command, a data byte in place of an acknowledge, and commands issued while the unit is busy. A later read then shows that none of these changed any flag. Back-pressure patterns on `out_ready` show whether bytes stay stable and whether input is held off until each byte has left.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;
  localparam int BYTE_W = 8;
  localparam int BP_W   = 2;

  localparam logic [BYTE_W-1:0] OP_READ_STS  = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WR_ENABLE = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WR_BLOCK  = 8'h04;
  localparam logic [BYTE_W-1:0] OP_WRITE_STS = 8'h01;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ADDR,
    SQ_CMD,
    SQ_PAYLOAD,
    SQ_SEND,
    SQ_ACK,
    SQ_SKIP
  } seq_t;
endpackage

// File: rtl/stsreg_busy_timer.sv
module stsreg_busy_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      remain_q <= '0;
    else if (start)
      remain_q <= CW'(CYCLES);
    else if (remain_q != '0)
      remain_q <= remain_q - 1'b1;
  end

  assign busy = (remain_q != '0);
  assign done = (remain_q == CW'(1)) && !start;
endmodule

// File: rtl/stsreg_flags.sv
module stsreg_flags
  import stsreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wel,
  input  logic              clr_wel,
  input  logic              load_bp,
  input  logic [BP_W-1:0]   new_bp,
  input  logic              busy,
  input  logic              done,
  output logic              wel,
  output logic [BYTE_W-1:0] status
);
  localparam int PAD_W = BYTE_W - BP_W - 2;

  logic [BP_W-1:0] bp_q;
  logic [BP_W-1:0] bp_pend_q;
  logic [BP_W-1:0] bp_view;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel       <= 1'b0;
      bp_q      <= '0;
      bp_pend_q <= '0;
    end else begin
      if (done)
        wel <= 1'b0;
      else if (set_wel)
        wel <= 1'b1;
      else if (clr_wel)
        wel <= 1'b0;

      if (load_bp)
        bp_pend_q <= new_bp;
      if (done)
        bp_q <= bp_pend_q;
    end
  end

  // pending protect values are what a reader sees during a write
  assign bp_view = busy ? bp_pend_q : bp_q;
  assign status  = {{PAD_W{1'b0}}, bp_view, wel, busy};
endmodule

// File: rtl/stsreg_cmd_fsm.sv
module stsreg_cmd_fsm
  import stsreg_pkg::*;
#(
  parameter logic [7:0] HDR_CODE = 8'h55,
  parameter logic [7:0] DEV_CODE = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_kind,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              out_ready,
  input  logic              wel,
  input  logic              busy,
  output logic              in_ready,
  output logic              out_valid,
  output logic              capture,
  output logic              set_wel,
  output logic              clr_wel,
  output logic              load_bp
);
  seq_t state_q, state_d;
  logic fire, byte_in, ack_in;

  assign in_ready  = (state_q != SQ_SEND);
  assign out_valid = (state_q == SQ_SEND);
  assign fire      = in_valid && in_ready;
  assign byte_in   = fire && !in_kind;
  assign ack_in    = fire && in_kind;

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    set_wel = 1'b0;
    clr_wel = 1'b0;
    load_bp = 1'b0;
    case (state_q)
      SQ_IDLE, SQ_SKIP: begin
        if (byte_in && in_data == HDR_CODE)
          state_d = SQ_ADDR;
      end
      SQ_ADDR: begin
        if (byte_in)
          state_d = (in_data == DEV_CODE) ? SQ_CMD : SQ_SKIP;
      end
      SQ_CMD: begin
        if (byte_in) begin
          state_d = SQ_SKIP;
          case (in_data)
            OP_READ_STS: begin
              capture = 1'b1;
              state_d = SQ_SEND;
            end
            OP_WR_ENABLE: if (!busy) begin
              set_wel = 1'b1;
              state_d = SQ_IDLE;
            end
            OP_WR_BLOCK: if (!busy) begin
              clr_wel = 1'b1;
              state_d = SQ_IDLE;
            end
            OP_WRITE_STS: if (!busy && wel) begin
              state_d = SQ_PAYLOAD;
            end
            default: state_d = SQ_SKIP;
          endcase
        end
      end
      SQ_PAYLOAD: begin
        if (byte_in) begin
          load_bp = 1'b1;
          state_d = SQ_IDLE;
        end
      end
      SQ_SEND: begin
        if (out_ready)
          state_d = SQ_ACK;
      end
      SQ_ACK: begin
        if (ack_in) begin
          if (in_data[0]) begin
            capture = 1'b1;
            state_d = SQ_SEND;
          end else begin
            state_d = SQ_IDLE;
          end
        end else if (byte_in) begin
          state_d = SQ_SKIP;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      state_q <= SQ_IDLE;
    else
      state_q <= state_d;
  end
endmodule

// File: rtl/stsreg_unit.sv
module stsreg_unit #(
  parameter int         WR_CYCLES = 40,
  parameter logic [7:0] HDR_CODE  = 8'h55,
  parameter logic [7:0] DEV_CODE  = 8'hA0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_kind,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  import stsreg_pkg::*;

  logic              capture, set_wel, clr_wel, load_bp;
  logic              wr_busy, wr_done, wel_q;
  logic [BYTE_W-1:0] status_now;
  logic [BYTE_W-1:0] out_q;

  stsreg_cmd_fsm #(
    .HDR_CODE(HDR_CODE),
    .DEV_CODE(DEV_CODE)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_kind  (in_kind),
    .in_data  (in_data),
    .out_ready(out_ready),
    .wel      (wel_q),
    .busy     (wr_busy),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .capture  (capture),
    .set_wel  (set_wel),
    .clr_wel  (clr_wel),
    .load_bp  (load_bp)
  );

  stsreg_busy_timer #(
    .CYCLES(WR_CYCLES)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(load_bp),
    .busy (wr_busy),
    .done (wr_done)
  );

  stsreg_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_wel(set_wel),
    .clr_wel(clr_wel),
    .load_bp(load_bp),
    .new_bp (in_data[3:2]),
    .busy   (wr_busy),
    .done   (wr_done),
    .wel    (wel_q),
    .status (status_now)
  );

  // each sent byte is a fresh sample of the live flags
  always_ff @(posedge clk) begin
    if (!rst_n)
      out_q <= '0;
    else if (capture)
      out_q <= status_now;
  end

  assign out_data = out_q;
endmodule

// File: rtl/stsreg_chk.sv
module stsreg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       wr_busy,
  input logic       wel_bit
);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10
  in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R2
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[7:4] == 4'h0);

  // R6
  end_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_busy) |-> !wel_bit);

  // R5
  start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy) |-> $past(wel_bit));

  // R9
  busy_keeps_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> wel_bit);
endmodule

bind stsreg_unit stsreg_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .wr_busy  (wr_busy),
  .wel_bit  (wel_q)
);

// File: tb/tb_stsreg_unit.sv
`timescale 1ns/1ps
module tb_stsreg_unit;
  localparam int WR = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_kind = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid;
  logic [7:0] out_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rdy_mode = 0;
  bit ended = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  logic       wel_m = 1'b0;
  logic [1:0] bp_m = 2'b00;
  logic [1:0] pend_m = 2'b00;
  bit         wr_act = 0;
  int         e_wr = 0;

  stsreg_unit #(.WR_CYCLES(WR)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference model, evaluated at the edge where a token is taken
  function automatic void step(int c);
    if (wr_act && c > e_wr + WR) begin
      wel_m  = 1'b0;
      bp_m   = pend_m;
      wr_act = 0;
    end
  endfunction

  function automatic bit wip_at(int c);
    return wr_act && c > e_wr && c <= e_wr + WR;
  endfunction

  function automatic logic [7:0] exp_at(int c);
    step(c);
    return {4'b0000, wip_at(c) ? pend_m : bp_m, wel_m, wip_at(c)};
  endfunction

  task automatic send(bit k, logic [7:0] d, bit cap, string tag, output int fc);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_data = d;
    while (!in_ready) @(negedge clk);
    fc = cyc + 1;
    if (cap) begin
      exp_q.push_back(exp_at(fc));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rdsr(int polls, string tag);
    int fc;
    send(0, 8'h55, 0, tag, fc);
    send(0, 8'hA0, 0, tag, fc);
    send(0, 8'h05, 1, tag, fc);
    for (int i = 0; i < polls; i++) send(1, 8'h01, 1, tag, fc);
    send(1, 8'h00, 0, tag, fc);
  endtask

  task automatic wcmd(logic [7:0] op);
    int fc;
    send(0, 8'h55, 0, "", fc);
    send(0, 8'hA0, 0, "", fc);
    send(0, op, 0, "", fc);
    step(fc);
    if (!wip_at(fc)) begin
      if (op == 8'h06) wel_m = 1'b1;
      if (op == 8'h04) wel_m = 1'b0;
    end
  endtask

  task automatic wrsr(logic [1:0] bp);
    int fc, fd;
    bit ok;
    send(0, 8'h55, 0, "", fc);
    send(0, 8'hA0, 0, "", fc);
    send(0, 8'h01, 0, "", fc);
    step(fc);
    ok = wel_m && !wip_at(fc);
    send(0, {4'b0000, bp, 2'b00}, 0, "", fd);
    if (ok) begin
      pend_m = bp; wr_act = 1; e_wr = fd;
    end
  endtask

  // ready pattern is driven just after each rising edge
  initial forever begin
    @(posedge clk); #1;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3 != 1);
      default: out_ready = 1'b0;
    endcase
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && out_valid && out_ready) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R3: unexpected byte act=%h exp=none", out_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_data !== e) begin
          bad++;
          $display("FAIL %s: act=%h exp=%h", t, out_data, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: act=hung exp=done");
    report();
  end

  initial begin
    int fc;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state at the ports
    chk(in_ready === 1'b1, "R1", {7'b0, in_ready}, 8'h01);
    chk(out_valid === 1'b0, "R1", {7'b0, out_valid}, 8'h00);
    rst_n = 1'b1;

    rdsr(0, "R1");
    rdsr(3, "R3");
    repeat (5) @(negedge clk);
    chk(out_valid === 1'b0, "R3", {7'b0, out_valid}, 8'h00);

    wcmd(8'h06); rdsr(1, "R4");
    wcmd(8'h04); rdsr(0, "R4");

    // R5: write refused with WEL clear
    wrsr(2'b11); rdsr(0, "R5");

    // R8: wrong address, then unknown command
    send(0, 8'h55, 0, "", fc); send(0, 8'hA2, 0, "", fc); send(0, 8'h06, 0, "", fc);
    rdsr(0, "R8");
    send(0, 8'h55, 0, "", fc); send(0, 8'hA0, 0, "", fc); send(0, 8'h03, 0, "", fc);
    send(0, 8'h06, 0, "", fc);
    rdsr(0, "R8");

    // R7 / R6: polls across a status write under back-pressure
    wcmd(8'h06); wrsr(2'b10);
    rdy_mode = 1;
    rdsr(20, "R7");
    rdy_mode = 0;
    rdsr(0, "R6");

    // R9: disable and second write during busy have no effect
    wcmd(8'h06); wrsr(2'b01); wcmd(8'h04); rdsr(0, "R9");
    wrsr(2'b11);
    repeat (WR + 5) @(negedge clk);
    rdsr(1, "R9");

    // R3: data byte in place of an acknowledge ends the read
    send(0, 8'h55, 0, "", fc); send(0, 8'hA0, 0, "", fc); send(0, 8'h05, 1, "R3", fc);
    send(0, 8'h00, 0, "", fc);
    repeat (5) @(negedge clk);
    chk(out_valid === 1'b0, "R3", {7'b0, out_valid}, 8'h00);
    rdsr(0, "R3");

    // R10: held byte blocks input
    rdy_mode = 2;
    send(0, 8'h55, 0, "", fc); send(0, 8'hA0, 0, "", fc); send(0, 8'h05, 1, "R10", fc);
    repeat (4) @(negedge clk);
    chk(out_valid === 1'b1, "R10", {7'b0, out_valid}, 8'h01);
    chk(in_ready === 1'b0, "R10", {7'b0, in_ready}, 8'h00);
    rdy_mode = 0;
    send(1, 8'h00, 0, "", fc);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2", 8'(exp_q.size()), 8'h00);
    report();
  end
endmodule